// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus. It sits in front of a 512 x 8 storage array that is built from on-chip registers. A fast system clock samples the serial clock and data lines. The block finds start and stop conditions and decodes the select byte. On a write it loads a low address byte. It then streams data into or out of the array through a 9-bit address latch that advances on its own. The data line is open drain: the block only pulls it low, and a pull-up on the bus provides the high level.

The select byte has a fixed device-type code in its upper nibble and two bits that must equal the `selPins` strap. Below those come a page bit, which is the ninth address bit, and the direction bit. The bus master can set a random read address by starting a write, sending the low address byte, and then issuing a repeated start with a read. A plain read carries on from the location after the last access. A write-protect input stops the array from changing and holds the address.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data line is released, and the address latch holds 000h, so a page-0 read that follows reset returns the byte at 000h. The array itself is not cleared by reset.
- R2: The select byte is decoded as follows. Bits 7..4 must be 1010b. Bit 3 must equal `selPins[1]` and bit 2 must equal `selPins[0]`. Bit 1 is the page (address bit 8) and bit 0 is the direction (0 = write, 1 = read). A matching byte is acknowledged by pulling the data line low during the ninth clock. A byte that does not match gets no acknowledge, and all later bytes are ignored until the next start.
- R3: On a write, the byte after the select byte is address bits 7..0, and the page bit supplies bit 8. Each later data byte is stored at the 9-bit latched address and acknowledged, and the address then increases by one.
- R4: A read has no address byte. It begins at the latched low 8 bits combined with the page bit of the current select byte. Each master acknowledge makes the block send the next sequential byte, and a new read carries on after the last byte accessed.
- R5: The address latch wraps from 1FFh to 000h on both writes and reads, inside one transfer.
- R6: A stop condition that arrives before the 8th bit of a data byte leaves the array and the address latch unchanged.
- R7: While `wpIn` is high, a write data byte gets no acknowledge, the array is not changed, and the address latch does not advance. The address byte is still accepted.
- R8: A master no-acknowledge after a read byte ends the read, and the block keeps the data line released until the next start.
- R9: A start condition at any point, including a repeated start with no stop before it, abandons the current transfer and waits for a new select byte.
- R10: Bits travel MSB first. The block samples the data line on the rising serial clock edge. It changes its own drive only after a falling serial clock edge, and it never pulls the line low while the master is driving a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad (wired level) |
| wpIn | input | 1 | Write protect; high blocks all array writes |
| selPins | input | 2 | Strap compared with select-byte bits 3 (bit 1) and 2 (bit 0) |
| sdaPullLow | output | 1 | High to pull the data line low (open-drain enable) |

## Verification
The address latch cannot be seen at the ports. A wrong latch value only shows up later, as a wrong byte on the following read, or as a byte written to the wrong place and found by a later read. For that reason every write in the bench is read back, including reads that continue after a reset, a protected write, an aborted byte or a wrap. A wrong state in the bus sequencer shows up sooner, in the ninth clock of the same byte: a missing acknowledge, an acknowledge that should not be there, or the block pulling the line during a master bit. The bench catches these as ack mismatches and as a per-cycle contention count.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  localparam int BYTE_W   = 8;
  localparam int PAGE_W   = 1;
  localparam int ADDR_W   = BYTE_W + PAGE_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int SYNC_LEN = 2;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_ACK, ST_ACKHOLD,
    ST_RDATA, ST_MACK, ST_RNEXT, ST_IGNORE
  } busState_t;

  typedef enum logic [1:0] {
    NX_WORD, NX_WDATA, NX_READ
  } nextPhase_t;

  typedef struct packed {
    logic shiftIn;
    logic devLoad;
    logic wordLoad;
    logic memWrite;
    logic addrInc;
    logic txLoad;
    logic txShift;
  } dpStrobe_t;
endpackage

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic [1:0] selPins,
  input  logic [5:0] devId,
  input  logic       rwBit,
  input  logic       txNext,
  input  logic       memRdMsb,
  output dpStrobe_t  strb,
  output logic       sdaBit,
  output logic       pullLow
);
  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t  state;
  nextPhase_t nextPhase;
  logic [CNT_W-1:0] bitCnt;
  logic lastBit, devMatch;

  // two-flop synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_LEN-1];
  assign sdaS     = sdaPipe[SYNC_LEN-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign lastBit  = (bitCnt == CNT_W'(BYTE_W - 1));
  assign devMatch = (devId[5:2] == DEV_TYPE) && (devId[1:0] == selPins);

  always_comb begin
    strb = '0;
    if (!startDet && !stopDet) begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            if (lastBit) begin
              strb.devLoad  = (state == ST_DEV) && devMatch;
              strb.wordLoad = (state == ST_WORD);
              strb.memWrite = (state == ST_WDATA) && !wpIn;
            end
          end
        end
        ST_RDATA: begin
          strb.addrInc = sclRise && lastBit;
          strb.txShift = sclFall;
        end
        ST_ACKHOLD: strb.txLoad = sclFall && (nextPhase == NX_READ);
        ST_RNEXT:   strb.txLoad = sclFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nextPhase <= NX_WORD;
      bitCnt    <= '0;
      pullLow   <= 1'b0;
    end else if (startDet) begin
      state   <= ST_DEV;
      bitCnt  <= '0;
      pullLow <= 1'b0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
      pullLow <= 1'b0;
    end else begin
      case (state)
        ST_DEV: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            state     <= devMatch ? ST_ACK : ST_IGNORE;
            nextPhase <= rwBit ? NX_READ : NX_WORD;
          end
        end
        ST_WORD: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            state     <= ST_ACK;
            nextPhase <= NX_WDATA;
          end
        end
        ST_WDATA: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) state <= wpIn ? ST_IGNORE : ST_ACK;
        end
        ST_ACK: if (sclFall) begin
          pullLow <= 1'b1;
          state   <= ST_ACKHOLD;
        end
        ST_ACKHOLD: if (sclFall) begin
          bitCnt <= '0;
          if (nextPhase == NX_READ) begin
            pullLow <= ~memRdMsb;
            state   <= ST_RDATA;
          end else begin
            pullLow <= 1'b0;
            state   <= (nextPhase == NX_WORD) ? ST_WORD : ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) state <= ST_MACK;
          end
          if (sclFall) pullLow <= ~txNext;
        end
        ST_MACK: begin
          if (sclFall) pullLow <= 1'b0;
          if (sclRise) state <= sdaS ? ST_IGNORE : ST_RNEXT;
        end
        ST_RNEXT: if (sclFall) begin
          bitCnt  <= '0;
          pullLow <= ~memRdMsb;
          state   <= ST_RDATA;
        end
        default: ;
      endcase
    end
  end

  // R10: own drive changes only after a falling clock edge or a bus condition
  a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    (pullLow != $past(pullLow)) |-> ($past(sclFall) || $past(startDet) || $past(stopDet)));

  // R8: a stop always leaves the line released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !pullLow);

  // R2: while ignoring the bus the line is never pulled
  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !pullLow);

  // R9: a start returns the sequencer to select-byte reception
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_DEV) && (bitCnt == '0));
endmodule

// File: rtl/twi_mem_data.sv
module twi_mem_data
  import twi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txNext,
  output logic              memRdMsb
);
  logic [BYTE_W-1:0] rxReg;
  logic [BYTE_W-2:0] txReg;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] memArr [DEPTH];
  logic [BYTE_W-1:0] memRd;

  assign rxByte   = {rxReg[BYTE_W-2:0], sdaBit};
  assign memRd    = memArr[addr];
  assign memRdMsb = memRd[BYTE_W-1];
  assign txNext   = txReg[BYTE_W-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      addr  <= '0;
    end else begin
      if (strb.shiftIn) rxReg <= rxByte;
      if (strb.devLoad) addr[ADDR_W-1] <= rxByte[1];
      if (strb.wordLoad) addr[BYTE_W-1:0] <= rxByte;
      if (strb.memWrite || strb.addrInc) addr <= addr + ADDR_W'(1);
      if (strb.txLoad) txReg <= memRd[BYTE_W-2:0];
      else if (strb.txShift) txReg <= {txReg[BYTE_W-3:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWrite) memArr[addr] <= rxByte;
  end

  // R5: the latch rolls over from the top location to zero
  a_r5_addr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.memWrite || strb.addrInc) && (addr == '1)) |=> (addr == '0));

  // R1: address and load strobes never overlap
  a_r1_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wordLoad, strb.memWrite, strb.addrInc}));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic [1:0] selPins,
  output logic       sdaPullLow
);
  dpStrobe_t         strb;
  logic              sdaBit, txNext, memRdMsb;
  logic [BYTE_W-1:0] rxByte;

  twi_mem_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wpIn(wpIn),
    .selPins(selPins), .devId(rxByte[7:2]), .rwBit(rxByte[0]),
    .txNext(txNext), .memRdMsb(memRdMsb), .strb(strb),
    .sdaBit(sdaBit), .pullLow(sdaPullLow)
  );

  twi_mem_data data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txNext(txNext), .memRdMsb(memRdMsb)
  );

  // R7: a protected write never reaches the array
  a_r7_wp_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWrite |-> !wpIn);
endmodule

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb_top;
  localparam int Q = 5;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wpIn = 1'b0;
  logic sdaPullLow, sdaLine;
  logic masterDrives = 1'b0;
  int checks = 0, failures = 0, contention = 0;
  bit done = 1'b0;

  logic [7:0] refMem [0:511];
  logic [8:0] refAddr = '0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  twi_mem_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .wpIn(wpIn),
    .selPins(SEL), .sdaPullLow(sdaPullLow)
  );

  // per-cycle reference check: slave silent while master owns a bit (R10)
  always @(negedge clk) if (rstN && masterDrives && sdaPullLow) contention++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    tick(Q); sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    tick(Q); sdaM = b; masterDrives = 1'b1; tick(Q); sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; masterDrives = 1'b0;
  endtask

  task automatic recvBit(output logic v);
    sdaM = 1'b1; tick(2*Q); sclM = 1'b1; tick(Q); v = sdaLine; tick(Q); sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic v;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    recvBit(v);
    acked = !v;
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin recvBit(v); d[i] = v; end
    sendBit(!mAck);
  endtask

  task automatic wrBegin(input logic pg, input logic [7:0] word);
    bit a;
    busStart();
    sendByte({4'b1010, SEL, pg, 1'b0}, a);
    chk(a, "R2 select ack (write)", a, 1);
    sendByte(word, a);
    chk(a, "R3 address byte ack", a, 1);
    refAddr = {pg, word};
  endtask

  task automatic wrData(input logic [7:0] d);
    bit a;
    sendByte(d, a);
    if (wpIn) chk(!a, "R7 protected byte not acked", a, 0);
    else begin
      chk(a, "R3 data ack", a, 1);
      refMem[refAddr] = d;
      refAddr = refAddr + 9'd1;
    end
  endtask

  task automatic rdBegin(input logic pg, input string tag);
    bit a;
    busStart();
    sendByte({4'b1010, SEL, pg, 1'b1}, a);
    chk(a, tag, a, 1);
    refAddr[8] = pg;
  endtask

  task automatic rdData(input bit last, input string tag);
    logic [7:0] d;
    recvByte(!last, d);
    chk(d === refMem[refAddr], tag, d, refMem[refAddr]);
    refAddr = refAddr + 9'd1;
    if (last) begin
      tick(3);
      chk(!sdaPullLow, "R8 released after master nack", sdaPullLow, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a;
    tick(4); rstN = 1'b1; tick(4);
    chk(!sdaPullLow, "R1 line released after reset", sdaPullLow, 0);

    // R3: plain writes, then R1: reset clears the latch but not the array
    wrBegin(1'b0, 8'h00); wrData(8'h5A); busStop();
    wrBegin(1'b0, 8'h10);
    wrData(8'hA1); wrData(8'hB2); wrData(8'hC3); wrData(8'hD4); busStop();
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(3); refAddr = '0;
    rdBegin(1'b0, "R1 select ack after reset");
    rdData(1'b1, "R1 read at 000h after reset"); busStop();

    // R9: repeated start turns a write header into a random read; R4 streaming
    wrBegin(1'b0, 8'h10);
    rdBegin(1'b0, "R9 select ack after repeated start");
    rdData(1'b0, "R9 random read first byte");
    rdData(1'b0, "R4 sequential read second byte");
    rdData(1'b1, "R4 sequential read third byte");
    busStop();
    rdBegin(1'b0, "R4 select ack current read");
    rdData(1'b1, "R4 current read continues after last access");
    busStop();

    // R2: mismatching strap and device type are ignored
    busStart();
    sendByte({4'b1010, ~SEL, 1'b0, 1'b0}, a);
    chk(!a, "R2 strap mismatch not acked", a, 0);
    sendByte(8'h55, a);
    chk(!a, "R2 bus ignored after mismatch", a, 0);
    busStop();
    busStart();
    sendByte({4'b1011, SEL, 1'b0, 1'b1}, a);
    chk(!a, "R2 device type mismatch not acked", a, 0);
    busStop();

    // R3: page bit selects the upper half
    wrBegin(1'b1, 8'h20); wrData(8'hC3); busStop();
    wrBegin(1'b0, 8'h20); wrData(8'h3C); busStop();
    wrBegin(1'b1, 8'h20); rdBegin(1'b1, "R2 read select page 1");
    rdData(1'b1, "R3 page 1 location"); busStop();
    wrBegin(1'b0, 8'h20); rdBegin(1'b0, "R2 read select page 0");
    rdData(1'b1, "R3 page 0 location"); busStop();

    // R5: wrap from 1FFh to 000h on write and read
    wrBegin(1'b1, 8'hFF); wrData(8'hAA); wrData(8'hBB); busStop();
    wrBegin(1'b1, 8'hFF); rdBegin(1'b1, "R5 select ack");
    rdData(1'b0, "R5 read at 1FFh"); rdData(1'b1, "R5 read wraps to 000h");
    busStop();

    // R6: stop before the 8th bit leaves array and latch alone
    wrBegin(1'b0, 8'h30); wrData(8'h00); wrData(8'h11); busStop();
    wrBegin(1'b0, 8'h30); wrData(8'h77);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    rdBegin(1'b0, "R6 select ack");
    rdData(1'b1, "R6 location after aborted byte unchanged");
    busStop();

    // R7: write protect
    wrBegin(1'b0, 8'h40); wrData(8'h22); wrData(8'h33); busStop();
    wpIn = 1'b1;
    wrBegin(1'b0, 8'h40); wrData(8'h99); busStop();
    wpIn = 1'b0;
    rdBegin(1'b0, "R7 select ack");
    rdData(1'b0, "R7 array unchanged, latch not advanced");
    rdData(1'b1, "R7 next location intact");
    busStop();

    chk(contention == 0, "R10 slave pulled line during master bit", contention, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule